// File: doc/BRIEF.md
# Transceiver Event Interrupt Controller

This block is the interrupt collector on the management side of an Ethernet transceiver. The datapath sends it fifteen single-cycle event pulses. Examples are link state changes, descrambler sync changes, error-counter wraps and auto-negotiation milestones. Each pulse is held in a sticky status bit, and a single active-high interrupt line is raised for every held event whose enable bit is set.

Software reaches the block through a plain register port with a write enable, a read enable, a 5-bit address and 16-bit data. The enable register lives at address 0x10 and the event register at address 0x11. Reading the event register returns what is pending and clears it. A compatibility-mode input takes the four highest enables out of service for as long as it is asserted.

Top module: `phy_irq_ctrl`

## Requirements
- R1: After reset, the enable register reads 0x4000 (only bit 14 set), the event register reads 0x0000 and irq_o is low.
- R2: An event pulse on evt_i[n] (n from 1 to 15) sets event bit n at the next clock edge whether or not it is enabled. The bit then stays set until a read clears it. Bit meanings: 15 link unstable, 14 link change, 13 descrambler sync change, 12 premature end, 11..9 counter wraps, 8 remote loopback fault, 7 reset done, 6 jabber, 5 auto-negotiation done, 4 parallel detect fault, 3 parallel fail, 2 remote fault, 1 page received.
- R3: A read at address 0x11 returns the event register in the same cycle on rdata_o. The bits it returned are cleared at that clock edge. An event pulse that arrives in the same cycle as the read stays set.
- R4: irq_o is registered. In each cycle it equals the OR over all bits of (event AND effective enable), taken from the previous cycle.
- R5: Address 0x10 is read/write and holds the enable register. Bit 0 reads as 0 and ignores writes.
- R6: While compat_mode_i is high, enable bits 15..12 read as 0 and are left out of the interrupt, and writes to them are ignored. Their stored values come back when compat_mode_i goes low.
- R7: Writes to 0x11 or to any other address change nothing. Reads from any address other than 0x10 or 0x11 return 0, and evt_i[0] is ignored.
- R8: An event whose enable bit is 0 never raises irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| compat_mode_i | input | 1 | Takes enables 15..12 out of service |
| evt_i | input | 16 | Single-cycle event pulses; bit 0 unused |
| we_i | input | 1 | Register write enable |
| re_i | input | 1 | Register read enable |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the cycle re_i is high |
| irq_o | output | 1 | Interrupt, active high |

## Verification
Two things can land on the same clock edge: a status read that clears the event register, and a new event pulse that sets a bit in it. The bench provokes this by first leaving one event pending and then reading the register while another event pulses, or the same one again, over every pair of bits. The result is judged from the value the next read returns and from irq_o, both compared against an arithmetic model that keeps bits raised in the read cycle.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int unsigned DW        = 16;
  localparam int unsigned AW        = 5;
  localparam logic [AW-1:0] MASK_ADDR = 5'h10;
  localparam logic [AW-1:0] STAT_ADDR = 5'h11;
  localparam int unsigned LOCK_LO   = 12;
  localparam int unsigned LOCK_HI   = 15;
  localparam logic [DW-1:0] MASK_RST = 16'h4000;
endpackage

// File: rtl/phy_irq_mask_reg.sv
module phy_irq_mask_reg #(
  parameter int unsigned DW = 16,
  parameter int unsigned LOCK_LO = 12,
  parameter int unsigned LOCK_HI = 15,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          compat_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] eff_o
);
  logic [DW-1:0] mask_q;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (b == 0) begin : g_rsvd
      assign mask_q[b] = 1'b0 & wdata_i[b];
      assign eff_o[b]  = 1'b0;
    end else if (b >= LOCK_LO && b <= LOCK_HI) begin : g_lock
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)                mask_q[b] <= RST_VAL[b];
        else if (wr_i && !compat_i) mask_q[b] <= wdata_i[b];
      assign eff_o[b] = mask_q[b] & ~compat_i;
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)   mask_q[b] <= RST_VAL[b];
        else if (wr_i) mask_q[b] <= wdata_i[b];
      assign eff_o[b] = mask_q[b];
    end
  end
endmodule

// File: rtl/phy_irq_stat_reg.sv
module phy_irq_stat_reg #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] evt_i,
  input  logic          clr_i,
  output logic [DW-1:0] stat_o
);
  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (b == 0) begin : g_rsvd
      assign stat_o[b] = 1'b0 & evt_i[b];
    end else begin : g_evt
      // set wins over clear-on-read
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)        stat_o[b] <= 1'b0;
        else if (evt_i[b])  stat_o[b] <= 1'b1;
        else if (clr_i)     stat_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/phy_irq_out.sv
module phy_irq_out #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] stat_i,
  input  logic [DW-1:0] eff_i,
  output logic          irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(stat_i & eff_i);
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
  import phy_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          compat_mode_i,
  input  logic [DW-1:0] evt_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [DW-1:0] stat_q, mask_eff;
  logic          mask_wr, stat_rd;

  assign mask_wr = we_i && (addr_i == MASK_ADDR);
  assign stat_rd = re_i && (addr_i == STAT_ADDR);

  phy_irq_mask_reg #(.DW(DW), .LOCK_LO(LOCK_LO), .LOCK_HI(LOCK_HI), .RST_VAL(MASK_RST)) u_mask (
    .clk_i, .rst_ni, .wr_i(mask_wr), .compat_i(compat_mode_i), .wdata_i, .eff_o(mask_eff)
  );

  phy_irq_stat_reg #(.DW(DW)) u_stat (
    .clk_i, .rst_ni, .evt_i, .clr_i(stat_rd), .stat_o(stat_q)
  );

  phy_irq_out #(.DW(DW)) u_irq (
    .clk_i, .rst_ni, .stat_i(stat_q), .eff_i(mask_eff), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      if (addr_i == MASK_ADDR)      rdata_o = mask_eff;
      else if (addr_i == STAT_ADDR) rdata_o = stat_q;
    end
  end
endmodule

// File: rtl/phy_irq_chk.sv
module phy_irq_chk
  import phy_irq_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          compat_mode_i,
  input logic [DW-1:0] evt_i,
  input logic          we_i,
  input logic          re_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] rdata_o,
  input logic          irq_o,
  input logic [DW-1:0] stat_q,
  input logic [DW-1:0] mask_eff
);
  logic [DW-1:0] evt_v;
  logic          rd_stat;
  assign evt_v   = evt_i & ~DW'(1);
  assign rd_stat = re_i && (addr_i == STAT_ADDR);

  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(evt_v)) == $past(evt_v))); // R2
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R2
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && evt_v == '0) |=> (stat_q == '0)); // R3
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & mask_eff) == '0) |=> !irq_o); // R8
  AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & mask_eff) != '0) |=> irq_o); // R4
  AST_COMPAT_HIDES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    compat_mode_i |-> (mask_eff[LOCK_HI:LOCK_LO] == '0)); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |-> (rdata_o[0] == 1'b0)); // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i != MASK_ADDR && addr_i != STAT_ADDR) |-> (rdata_o == '0)); // R7
endmodule

bind phy_irq_ctrl phy_irq_chk u_chk (
  .clk_i, .rst_ni, .compat_mode_i, .evt_i, .we_i, .re_i, .addr_i,
  .rdata_o, .irq_o, .stat_q, .mask_eff
);

// File: tb/tb_phy_irq_ctrl.sv
`timescale 1ns/1ps
module tb_phy_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        compat = 1'b0;
  logic [15:0] evt = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int unsigned nvec = 0, nerr = 0;
  logic [15:0] m_mask, m_stat;
  logic        m_irq;

  always #4 clk = ~clk;

  phy_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .compat_mode_i(compat), .evt_i(evt),
    .we_i(we), .re_i(re), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [15:0] eff_mask(input logic [15:0] m, input logic c);
    return m & (c ? 16'h0FFE : 16'hFFFE);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, check before posedge, update model at posedge
  task automatic cyc(input string tag, input logic w, input logic r, input logic [4:0] a,
                     input logic [15:0] d, input logic [15:0] e, input logic c);
    logic [15:0] exp_rd;
    logic        nxt_irq;
    @(negedge clk);
    we = w; re = r; addr = a; wdata = d; evt = e; compat = c;
    #1;
    chk({tag, " R4 irq"}, {15'd0, irq}, {15'd0, m_irq});
    if (r) begin
      if (a == 5'h10)      exp_rd = eff_mask(m_mask, c);
      else if (a == 5'h11) exp_rd = m_stat;
      else                 exp_rd = '0;
      chk({tag, " rdata"}, rdata, exp_rd);
    end
    @(posedge clk);
    nxt_irq = |(m_stat & eff_mask(m_mask, c));
    if (w && a == 5'h10)
      m_mask = c ? {m_mask[15:12], d[11:1], 1'b0} : {d[15:1], 1'b0};
    if (r && a == 5'h11) m_stat = '0;
    m_stat = m_stat | (e & 16'hFFFE);
    m_irq = nxt_irq;
  endtask

  task automatic idle(input string tag, input logic c);
    cyc(tag, 1'b0, 1'b0, 5'h0, 16'h0, 16'h0, c);
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    m_mask = 16'h4000; m_stat = '0; m_irq = 1'b0;
    #20 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 irq", {15'd0, irq}, 16'h0);
    cyc("R1 mask", 1'b0, 1'b1, 5'h10, 16'h0, 16'h0, 1'b0);
    cyc("R1 stat", 1'b0, 1'b1, 5'h11, 16'h0, 16'h0, 1'b0);
    chk("R1 mask value", m_mask, 16'h4000);

    // R2 R8 R4: every event bit, enabled and disabled
    for (int i = 0; i < 16; i++) begin
      for (int en = 0; en < 2; en++) begin
        cyc("R5 wr", 1'b1, 1'b0, 5'h10, en ? 16'(1 << i) : 16'h0, 16'h0, 1'b0);
        cyc("R2 evt", 1'b0, 1'b0, 5'h0, 16'h0, 16'(1 << i), 1'b0);
        idle("R8", 1'b0);
        idle("R8", 1'b0);
        cyc("R2 rd", 1'b0, 1'b1, 5'h11, 16'h0, 16'h0, 1'b0);
        idle("R3", 1'b0);
        cyc("R3 rd", 1'b0, 1'b1, 5'h11, 16'h0, 16'h0, 1'b0);
      end
    end

    // R5 mask readback patterns
    for (int p = 0; p < 16; p++) begin
      cyc("R5 wr", 1'b1, 1'b0, 5'h10, 16'(32'h1111 * p) ^ 16'hA5A5, 16'h0, 1'b0);
      cyc("R5 rd", 1'b0, 1'b1, 5'h10, 16'h0, 16'h0, 1'b0);
    end

    // R6 compat lock
    cyc("R6 wr", 1'b1, 1'b0, 5'h10, 16'hFFFF, 16'h0, 1'b0);
    cyc("R6 rd", 1'b0, 1'b1, 5'h10, 16'h0, 16'h0, 1'b1);
    cyc("R6 wr", 1'b1, 1'b0, 5'h10, 16'h0000, 16'h0, 1'b1);
    cyc("R6 rd", 1'b0, 1'b1, 5'h10, 16'h0, 16'h0, 1'b1);
    cyc("R6 evt", 1'b0, 1'b0, 5'h0, 16'h0, 16'hF000, 1'b1);
    idle("R6", 1'b1);
    idle("R6", 1'b1);
    cyc("R6 rd", 1'b0, 1'b1, 5'h10, 16'h0, 16'h0, 1'b0);
    idle("R6", 1'b0);
    idle("R6", 1'b0);
    cyc("R6 rd", 1'b0, 1'b1, 5'h11, 16'h0, 16'h0, 1'b0);
    chk("R6 stored", m_mask, 16'hF000);
    cyc("R6 wr", 1'b1, 1'b0, 5'h10, 16'h0000, 16'h0, 1'b0);

    // R3 read and event in the same cycle, all pairs
    cyc("R3 wr", 1'b1, 1'b0, 5'h10, 16'hFFFF, 16'h0, 1'b0);
    for (int i = 1; i < 16; i++) begin
      for (int j = 1; j < 16; j++) begin
        cyc("R3 pend", 1'b0, 1'b0, 5'h0, 16'h0, 16'(1 << j), 1'b0);
        cyc("R3 rd+evt", 1'b0, 1'b1, 5'h11, 16'h0, 16'(1 << i), 1'b0);
        idle("R3", 1'b0);
        cyc("R3 rd", 1'b0, 1'b1, 5'h11, 16'h0, 16'h0, 1'b0);
      end
    end

    // R7 all addresses, writes to non-mask addresses, evt bit 0
    cyc("R7 wr", 1'b1, 1'b0, 5'h10, 16'h0F0E, 16'h0, 1'b0);
    for (int a = 0; a < 32; a++) begin
      if (a != 16) cyc("R7 wr", 1'b1, 1'b0, 5'(a), 16'hFFFF, 16'h0, 1'b0);
      cyc("R7 rd", 1'b0, 1'b1, 5'(a), 16'h0, 16'h0, 1'b0);
    end
    cyc("R7 evt0", 1'b0, 1'b0, 5'h0, 16'h0, 16'h0001, 1'b0);
    idle("R7", 1'b0);
    cyc("R7 rd", 1'b0, 1'b1, 5'h11, 16'h0, 16'h0, 1'b0);
    idle("R7", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule